// File: doc/BRIEF.md
# Protected Event Interrupt Controller

This block collects single-cycle event pulses from several pixel pipelines. Each pipeline raises three events: a shadow-register load, a finished frame and a finished sequence. Each event has its own sticky status bit. Software can force that bit to one or clear it through a small register port. Every event can be sent to a maskable interrupt line, to a non-maskable line, or to both. The untouched event pulses are also passed straight through, so that a system-level interrupt controller can take them instead.

The register port is a simple single-cycle access port. A write takes effect at the clock edge where `bus_we` is high. Read data follows `bus_addr` combinationally. A privilege qualifier comes with each write. Each event has a lock bit. While the lock bit is set, a write without privilege cannot change that event's enable, routing or status bits, and only a privileged write can change the lock bits themselves.

Event bit `3*p + k` belongs to pipeline `p`, where `k` is 0 for shadow load, 1 for frame complete and 2 for sequence complete. The data width equals the event count. These are plain control and status pins with no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero and both `irq_o` and `nmi_o` are low. The word addresses are: 0 enable, 1 status, 2 set-strobe, 3 clear-strobe, 4 IRQ route, 5 NMI route, 6 lock. Addresses 2, 3 and 7 always read zero.
- R2: An event pulse on `ev_i[i]` sets status bit i at the next clock edge. The bit stays set, with no further pulse, until it is cleared.
- R3: `raw_o` equals `ev_i` in the same cycle, whatever the enable, route and lock state.
- R4: A write to address 2 sets every status bit whose written bit is one and leaves the bits written as zero unchanged.
- R5: A write to address 3 clears every status bit whose written bit is one and leaves the others unchanged. A write to address 1 has no effect.
- R6: If an event pulse and a clear of the same bit arrive in the same cycle, that status bit ends up set. Cleared bits with no pulse still clear.
- R7: `irq_o` is high exactly when some event has status, enable (address 0) and IRQ route (address 4) all set.
- R8: `nmi_o` is high exactly when some event has both status and NMI route (address 5) set, whatever its enable bit.
- R9: For a bit whose lock is set, a write with `bus_priv` low leaves that bit of enable, both routes and status unchanged. Unlocked bits in the same write still change. A write with `bus_priv` high changes the bit normally.
- R10: A write to the lock register (address 6) with `bus_priv` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_i | input | NUM_EV | Event pulses, bit 3p+k |
| bus_we | input | 1 | Write strobe |
| bus_priv | input | 1 | Write is privileged |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | NUM_EV | Write data |
| bus_rdata | output | NUM_EV | Read data for bus_addr |
| raw_o | output | NUM_EV | Unmasked event pass-through |
| irq_o | output | 1 | Maskable interrupt |
| nmi_o | output | 1 | Non-maskable interrupt |

## Verification
`raw_o` is combinational, so it is checked in the same cycle that the pulse is driven. A pulse or a register write changes state at the next rising edge. Read data, `irq_o` and `nmi_o` then reflect that state at once, with no extra register on the way. The bench's driver applies each stimulus just after a rising edge and queues the expected item. A monitor compares items at the following falling edge. Read and output checks first wait one full edge after the stimulus, so the state they observe is settled and the address is never changed while a comparison is pending.

// File: rtl/evic_pkg.sv
package evic_pkg;
  localparam int ADDR_W = 3;
  localparam int EVT_PER_PIPE = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_ENABLE = 3'd0,
    A_STATUS = 3'd1,
    A_SET    = 3'd2,
    A_CLEAR  = 3'd3,
    A_IRQ_RT = 3'd4,
    A_NMI_RT = 3'd5,
    A_LOCK   = 3'd6,
    A_SPARE  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/evic_ctrl_regs.sv
module evic_ctrl_regs
  import evic_pkg::*;
#(
  parameter int NUM_EV = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              priv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_EV-1:0] wdata,
  output logic [NUM_EV-1:0] enable,
  output logic [NUM_EV-1:0] irq_rt,
  output logic [NUM_EV-1:0] nmi_rt,
  output logic [NUM_EV-1:0] lock,
  output logic [NUM_EV-1:0] wmask
);
  // per-bit write permission: privileged or unlocked
  for (genvar i = 0; i < NUM_EV; i++) begin : g_perm
    assign wmask[i] = priv | ~lock[i];
  end

  function automatic logic [NUM_EV-1:0] merge(input logic [NUM_EV-1:0] old_v,
                                              input logic [NUM_EV-1:0] new_v,
                                              input logic [NUM_EV-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
      irq_rt <= '0;
      nmi_rt <= '0;
      lock   <= '0;
    end else if (we) begin
      case (addr)
        A_ENABLE: enable <= merge(enable, wdata, wmask);
        A_IRQ_RT: irq_rt <= merge(irq_rt, wdata, wmask);
        A_NMI_RT: nmi_rt <= merge(nmi_rt, wdata, wmask);
        A_LOCK:   if (priv) lock <= wdata;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/evic_status.sv
module evic_status #(
  parameter int NUM_EV = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev,
  input  logic [NUM_EV-1:0] set_stb,
  input  logic [NUM_EV-1:0] clr_stb,
  output logic [NUM_EV-1:0] status
);
  logic [NUM_EV-1:0] status_d;

  // hardware pulse is applied last so it wins over a clear
  always_comb status_d = (status & ~clr_stb) | set_stb | ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_d;
  end
endmodule

// File: rtl/evic_combine.sv
module evic_combine
  import evic_pkg::*;
#(
  parameter int NUM_PIPES = 4,
  localparam int NUM_EV = EVT_PER_PIPE * NUM_PIPES
) (
  input  logic [NUM_EV-1:0] status,
  input  logic [NUM_EV-1:0] enable,
  input  logic [NUM_EV-1:0] irq_rt,
  input  logic [NUM_EV-1:0] nmi_rt,
  output logic              irq,
  output logic              nmi
);
  logic [NUM_PIPES-1:0] pipe_irq, pipe_nmi;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    localparam int LO = p * EVT_PER_PIPE;
    assign pipe_irq[p] = |(status[LO +: EVT_PER_PIPE] & enable[LO +: EVT_PER_PIPE]
                           & irq_rt[LO +: EVT_PER_PIPE]);
    assign pipe_nmi[p] = |(status[LO +: EVT_PER_PIPE] & nmi_rt[LO +: EVT_PER_PIPE]);
  end

  assign irq = |pipe_irq;
  assign nmi = |pipe_nmi;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evic_pkg::*;
#(
  parameter int NUM_PIPES = 4,
  localparam int NUM_EV = EVT_PER_PIPE * NUM_PIPES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              bus_we,
  input  logic              bus_priv,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NUM_EV-1:0] bus_wdata,
  output logic [NUM_EV-1:0] bus_rdata,
  output logic [NUM_EV-1:0] raw_o,
  output logic              irq_o,
  output logic              nmi_o
);
  logic [NUM_EV-1:0] en_q, irq_rt_q, nmi_rt_q, lock_q, wmask;
  logic [NUM_EV-1:0] status_q, set_stb, clr_stb;

  evic_ctrl_regs #(.NUM_EV(NUM_EV)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .priv(bus_priv),
    .addr(bus_addr), .wdata(bus_wdata),
    .enable(en_q), .irq_rt(irq_rt_q), .nmi_rt(nmi_rt_q),
    .lock(lock_q), .wmask(wmask)
  );

  always_comb begin
    set_stb = '0;
    clr_stb = '0;
    if (bus_we && bus_addr == A_SET)   set_stb = bus_wdata & wmask;
    if (bus_we && bus_addr == A_CLEAR) clr_stb = bus_wdata & wmask;
  end

  evic_status #(.NUM_EV(NUM_EV)) u_status (
    .clk(clk), .rst_n(rst_n), .ev(ev_i),
    .set_stb(set_stb), .clr_stb(clr_stb), .status(status_q)
  );

  evic_combine #(.NUM_PIPES(NUM_PIPES)) u_comb (
    .status(status_q), .enable(en_q), .irq_rt(irq_rt_q), .nmi_rt(nmi_rt_q),
    .irq(irq_o), .nmi(nmi_o)
  );

  assign raw_o = ev_i;

  always_comb begin
    case (bus_addr)
      A_ENABLE: bus_rdata = en_q;
      A_STATUS: bus_rdata = status_q;
      A_IRQ_RT: bus_rdata = irq_rt_q;
      A_NMI_RT: bus_rdata = nmi_rt_q;
      A_LOCK:   bus_rdata = lock_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/evic_checker.sv
module evic_checker
  import evic_pkg::*;
#(
  parameter int NUM_EV = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_EV-1:0] ev_i,
  input logic              bus_we,
  input logic              bus_priv,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NUM_EV-1:0] bus_wdata,
  input logic [NUM_EV-1:0] raw_o,
  input logic              irq_o,
  input logic              nmi_o,
  input logic [NUM_EV-1:0] status,
  input logic [NUM_EV-1:0] enable,
  input logic [NUM_EV-1:0] lock
);
  assert_raw_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    raw_o == ev_i);

  assert_event_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_i) |=> ((status & $past(ev_i)) == $past(ev_i)));

  assert_user_lock_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_priv && bus_addr == A_LOCK) |=> $stable(lock));

  assert_locked_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_priv && bus_addr == A_ENABLE)
      |=> (((enable ^ $past(enable)) & $past(lock)) == '0));

  assert_priv_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_priv && bus_addr == A_CLEAR && ev_i == '0)
      |=> ((status & $past(bus_wdata)) == '0));

  assert_no_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> (!irq_o && !nmi_o));
endmodule

bind evt_irq_ctrl evic_checker #(.NUM_EV(NUM_EV)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .bus_we(bus_we), .bus_priv(bus_priv),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .raw_o(raw_o), .irq_o(irq_o),
  .nmi_o(nmi_o), .status(status_q), .enable(en_q), .lock(lock_q)
);

// File: tb/evt_irq_ctrl_bench.sv
`timescale 1ns/1ps
module evt_irq_ctrl_bench;
  localparam int N = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] ev_i = '0;
  logic         bus_we = 1'b0;
  logic         bus_priv = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata, raw_o;
  logic         irq_o, nmi_o;

  always #2.5 clk = ~clk;

  evt_irq_ctrl #(.NUM_PIPES(4)) u_evt_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .bus_we(bus_we), .bus_priv(bus_priv),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .raw_o(raw_o), .irq_o(irq_o), .nmi_o(nmi_o)
  );

  // kind 0: read data, 1: irq/nmi pair, 2: raw pass-through
  typedef struct {
    int           kind;
    logic [N-1:0] exp;
    string        tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [N-1:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = {{(N-2){1'b0}}, irq_o, nmi_o};
        default: act = raw_o;
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d, input logic p);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_priv = 1'b0;
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [N-1:0] e, input string tag);
    @(posedge clk); #1;
    bus_addr = a;
    q.push_back('{0, e, tag});
    @(negedge clk);
  endtask

  task automatic chk_out(input logic irq_e, input logic nmi_e, input string tag);
    @(posedge clk); #1;
    q.push_back('{1, {{(N-2){1'b0}}, irq_e, nmi_e}, tag});
    @(negedge clk);
  endtask

  // pulse events, optionally with a clear-strobe write in the same cycle
  task automatic pulse(input logic [N-1:0] ev, input logic [N-1:0] clr, input string tag);
    @(posedge clk); #1;
    ev_i = ev;
    if (clr != '0) begin
      bus_we = 1'b1; bus_addr = 3'd3; bus_wdata = clr; bus_priv = 1'b1;
    end
    q.push_back('{2, ev, tag});
    @(posedge clk); #1;
    ev_i = '0; bus_we = 1'b0; bus_priv = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) chk_rd(a[2:0], '0, "R1 reset read");
    chk_out(1'b0, 1'b0, "R1 reset outputs");

    // R3 / R2
    pulse(12'h005, '0, "R3 raw pass-through");
    chk_rd(3'd1, 12'h005, "R2 status set");
    chk_rd(3'd1, 12'h005, "R2 status sticky");
    chk_out(1'b0, 1'b0, "R7 unrouted quiet");

    // R7
    wr(3'd4, 12'h001, 1'b0);
    chk_out(1'b0, 1'b0, "R7 routed but disabled");
    wr(3'd0, 12'h001, 1'b0);
    chk_out(1'b1, 1'b0, "R7 enabled and routed");
    wr(3'd0, 12'h004, 1'b0);
    chk_out(1'b0, 1'b0, "R7 enable on unrouted bit");

    // R8
    wr(3'd0, 12'h000, 1'b0);
    wr(3'd5, 12'h004, 1'b0);
    chk_out(1'b0, 1'b1, "R8 nmi ignores enable");

    // R5 / R4
    wr(3'd3, 12'h004, 1'b1);
    chk_rd(3'd1, 12'h001, "R5 clear one bit");
    chk_out(1'b0, 1'b0, "R8 nmi drops after clear");
    wr(3'd2, 12'h0F0, 1'b0);
    chk_rd(3'd1, 12'h0F1, "R4 set strobe");
    wr(3'd2, 12'h000, 1'b1);
    chk_rd(3'd1, 12'h0F1, "R4 zero bits unchanged");
    wr(3'd1, 12'h000, 1'b1);
    chk_rd(3'd1, 12'h0F1, "R5 status write ignored");
    wr(3'd3, 12'h000, 1'b1);
    chk_rd(3'd1, 12'h0F1, "R5 zero clear unchanged");

    // R6
    pulse(12'h010, 12'h010, "R6 raw during clash");
    chk_rd(3'd1, 12'h0F1, "R6 event beats clear");
    pulse(12'h010, 12'h030, "R6 raw mixed");
    chk_rd(3'd1, 12'h0D1, "R6 other bit clears");

    // R10
    wr(3'd6, 12'hFFF, 1'b0);
    chk_rd(3'd6, 12'h000, "R10 user lock write ignored");
    wr(3'd6, 12'h00F, 1'b1);
    chk_rd(3'd6, 12'h00F, "R10 privileged lock write");

    // R9
    wr(3'd0, 12'hFFF, 1'b0);
    chk_rd(3'd0, 12'hFF0, "R9 user enable on locked bits");
    wr(3'd3, 12'h0FF, 1'b0);
    chk_rd(3'd1, 12'h001, "R9 user clear on locked bits");
    wr(3'd2, 12'h00E, 1'b0);
    chk_rd(3'd1, 12'h001, "R9 user set on locked bits");
    wr(3'd2, 12'h002, 1'b1);
    chk_rd(3'd1, 12'h003, "R9 privileged set");
    wr(3'd4, 12'h000, 1'b0);
    chk_rd(3'd4, 12'h001, "R9 user route on locked bits");
    wr(3'd0, 12'h001, 1'b1);
    chk_rd(3'd0, 12'h001, "R9 privileged enable");
    chk_out(1'b1, 1'b0, "R7 irq after privileged enable");
    pulse(12'h800, '0, "R3 raw with locks");
    chk_rd(3'd1, 12'h803, "R2 event on top pipeline");

    @(posedge clk); @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule